// File: doc/BRIEF.md
# AHB to synchronous SRAM bridge

This block is a zero-wait-state AHB slave that fronts a single-port synchronous RAM which is 32 bits wide and has one write strobe per byte. It takes 8-, 16- and 32-bit transfers. It drops the two low address bits to form a RAM word address. It also builds the byte write strobes from the transfer size and the low address bits, mapping bytes little-endian, with lane `i` on bits `8i+7:8i`.

A read claims the RAM port in its address phase, so the RAM word is there in the data phase. A write only supplies its data in the data phase. If the port is free in that cycle, the write goes straight to the RAM. If a read is using the port in that cycle, the write is parked in a one-entry buffer and is committed on the next cycle with no read. A read of a word whose write is still parked gets the parked bytes merged into the RAM word. The address width is a parameter.

Top module: `ahbram_bridge`

## Requirements
- R1: `hreadyout` is 1 and `hresp` is 2'b00 (OKAY) in every cycle after reset.
- R2: A transfer is accepted only when `hsel`, `hready` and `htrans[1]` are all high (`htrans` 2'b10 or 2'b11). IDLE (2'b00) or BUSY (2'b01) transfers, and transfers with `hsel` or `hready` low, leave the RAM contents unchanged.
- R3: `ram_addr` carries `haddr[AW-1:2]`. In the address phase of an accepted read, `ram_ce` is 1 and `ram_we` is 4'b0000 in that same cycle.
- R4: Write strobes follow `hsize`. 3'b000 (byte) sets bit `haddr[1:0]`. 3'b001 (halfword) sets 4'b0011 when `haddr[1]` is 0 and 4'b1100 when it is 1. 3'b010 (word) sets 4'b1111.
- R5: Every read returns the whole addressed 32-bit word on `hrdata`, in the cycle after its address phase, whatever its `hsize`.
- R6: A write whose data phase has a free port is issued to the RAM in that cycle (`ram_ce` 1, strobes per R4). If a read holds the port in that cycle, the write is held and then issued on the very next cycle with no read. At most one write is ever held.
- R7: A read of a word with a held write returns the held bytes for the lanes that write enables, and RAM bytes for the other lanes.
- R8: While `hresetn` is low, `ram_ce` and `ram_we` are 0. A held write is discarded by reset and never reaches the RAM.
- R9: `ram_addr` is `AW-2` bits wide. An `AW` outside 3 to 32 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready, previous transfer complete |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | 32 | Read data (data phase) |
| ram_ce | output | 1 | RAM access enable |
| ram_we | output | 4 | RAM byte write strobes |
| ram_addr | output | AW-2 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after the access |

## Verification
A held write that is lost or overwritten shows up only at a later read of that word. Such a read returns stale bytes in its data phase, which is the cycle right after its address phase, so the bench places reads immediately behind writes to the same word. A wrong strobe or a late commit is visible on `ram_we` and `ram_addr` in the write's data phase, or in the first read-free cycle after it, and the bench samples the RAM port in exactly those cycles. The effect of reset on a held write is only observable through a read issued after reset is released.

// File: rtl/ahbram_pkg.sv
package ahbram_pkg;
   localparam int BUS_W  = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = BUS_W / LANE_W;
   localparam int OFF_W  = $clog2(LANES);

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/ahbram_lane_dec.sv
module ahbram_lane_dec #(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic [OFF_W-1:0] off,
   input  logic [2:0]       size,
   output logic [LANES-1:0] be
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be[g] = (size == 3'd0) ? (off == OFF_W'(g)) :
                     (size == 3'd1) ? ((off >> 1) == OFF_W'(g >> 1)) :
                                      1'b1;
   end
endmodule

// File: rtl/ahbram_wbuf.sv
module ahbram_wbuf #(
   parameter int WA    = 14,
   parameter int DW    = 32,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rstn,
   input  logic             rd_start,
   input  logic [WA-1:0]    rd_addr,
   input  logic             dp_wr,
   input  logic [WA-1:0]    dp_addr,
   input  logic [LANES-1:0] dp_be,
   input  logic [DW-1:0]    wdata,
   output logic             ram_ce,
   output logic [LANES-1:0] ram_we,
   output logic [WA-1:0]    ram_addr,
   output logic [DW-1:0]    ram_wdata,
   output logic             wb_valid,
   output logic [WA-1:0]    wb_addr,
   output logic [LANES-1:0] wb_be,
   output logic [DW-1:0]    wb_data
);
   logic park;
   assign park = dp_wr & rd_start;

   always_comb begin
      ram_ce    = 1'b0;
      ram_we    = '0;
      ram_addr  = rd_addr;
      ram_wdata = wb_valid ? wb_data : wdata;
      if (rd_start) begin
         ram_ce = 1'b1;
      end else if (wb_valid) begin
         ram_ce   = 1'b1;
         ram_we   = wb_be;
         ram_addr = wb_addr;
      end else if (dp_wr) begin
         ram_ce   = 1'b1;
         ram_we   = dp_be;
         ram_addr = dp_addr;
      end
      if (!rstn) begin
         ram_ce = 1'b0;
         ram_we = '0;
      end
   end

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_be    <= '0;
         wb_data  <= '0;
      end else if (park) begin
         wb_valid <= 1'b1;
         wb_addr  <= dp_addr;
         wb_be    <= dp_be;
         wb_data  <= wdata;
      end else if (wb_valid && !rd_start) begin
         wb_valid <= 1'b0;
      end
   end

   assert_no_clobber_R6: assert property (@(posedge clk) disable iff (!rstn)
      dp_wr |-> !wb_valid);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rstn)
      (wb_valid && rd_start) |=> wb_valid);
   assert_drain_R6: assert property (@(posedge clk) disable iff (!rstn)
      (wb_valid && !rd_start) |=> !wb_valid);
endmodule

// File: rtl/ahbram_fwd.sv
module ahbram_fwd #(
   parameter int WA     = 14,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    dp_rd,
   input  logic [WA-1:0]           dp_addr,
   input  logic                    wb_valid,
   input  logic [WA-1:0]           wb_addr,
   input  logic [LANES-1:0]        wb_be,
   input  logic [LANES*LANE_W-1:0] wb_data,
   input  logic [LANES*LANE_W-1:0] ram_rdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   logic hit;
   assign hit = dp_rd & wb_valid & (wb_addr == dp_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign rdata[g*LANE_W +: LANE_W] = (hit && wb_be[g]) ?
         wb_data[g*LANE_W +: LANE_W] : ram_rdata[g*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/ahbram_bridge.sv
module ahbram_bridge
   import ahbram_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [AW-1:0]     haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [BUS_W-1:0]  hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic [1:0]        hresp,
   output logic [BUS_W-1:0]  hrdata,
   output logic              ram_ce,
   output logic [LANES-1:0]  ram_we,
   output logic [AW-3:0]     ram_addr,
   output logic [BUS_W-1:0]  ram_wdata,
   input  logic [BUS_W-1:0]  ram_rdata
);
   localparam int WA = AW - OFF_W;

   if (AW < 3 || AW > 32) begin : g_aw_range
      $error("ahbram_bridge: AW must lie in 3..32");
   end

   logic             xfer, rd_start, wr_start;
   logic [LANES-1:0] lane_be;
   logic             dp_wr, dp_rd;
   logic [WA-1:0]    dp_addr;
   logic [LANES-1:0] dp_be;
   logic             wb_valid;
   logic [WA-1:0]    wb_addr;
   logic [LANES-1:0] wb_be;
   logic [BUS_W-1:0] wb_data;

   assign xfer     = hresetn & hsel & hready &
                     (htrans_e'(htrans) == TR_NONSEQ || htrans_e'(htrans) == TR_SEQ);
   assign rd_start = xfer & ~hwrite;
   assign wr_start = xfer & hwrite;

   assign hreadyout = 1'b1;
   assign hresp     = RESP_OKAY;

   ahbram_lane_dec #(.LANES(LANES), .OFF_W(OFF_W)) u_lane (
      .off  (haddr[OFF_W-1:0]),
      .size (hsize),
      .be   (lane_be)
   );

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dp_wr   <= 1'b0;
         dp_rd   <= 1'b0;
         dp_addr <= '0;
         dp_be   <= '0;
      end else begin
         dp_wr <= wr_start;
         dp_rd <= rd_start;
         if (xfer) begin
            dp_addr <= haddr[AW-1:OFF_W];
            dp_be   <= lane_be;
         end
      end
   end

   ahbram_wbuf #(.WA(WA), .DW(BUS_W), .LANES(LANES)) u_wbuf (
      .clk       (hclk),
      .rstn      (hresetn),
      .rd_start  (rd_start),
      .rd_addr   (haddr[AW-1:OFF_W]),
      .dp_wr     (dp_wr),
      .dp_addr   (dp_addr),
      .dp_be     (dp_be),
      .wdata     (hwdata),
      .ram_ce    (ram_ce),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .wb_valid  (wb_valid),
      .wb_addr   (wb_addr),
      .wb_be     (wb_be),
      .wb_data   (wb_data)
   );

   ahbram_fwd #(.WA(WA), .LANES(LANES), .LANE_W(LANE_W)) u_fwd (
      .dp_rd     (dp_rd),
      .dp_addr   (dp_addr),
      .wb_valid  (wb_valid),
      .wb_addr   (wb_addr),
      .wb_be     (wb_be),
      .wb_data   (wb_data),
      .ram_rdata (ram_rdata),
      .rdata     (hrdata)
   );

   assert_rd_port_R3: assert property (@(posedge hclk) disable iff (!hresetn)
      rd_start |-> (ram_ce && ram_we == '0 && ram_addr == haddr[AW-1:OFF_W]));
   assert_byte_lane_R4: assert property (@(posedge hclk) disable iff (!hresetn)
      (wr_start && hsize == 3'd0) |-> ($countones(lane_be) == 1));
   assert_half_lane_R4: assert property (@(posedge hclk) disable iff (!hresetn)
      (wr_start && hsize == 3'd1) |-> ($countones(lane_be) == 2));
   assert_wr_issue_R6: assert property (@(posedge hclk) disable iff (!hresetn)
      (dp_wr && !rd_start) |-> (ram_ce && ram_we == dp_be && ram_addr == dp_addr));
endmodule

// File: tb/tb_ahbram_bridge.sv
`timescale 1ns/1ps
module tb_ahbram_bridge;
   localparam int AW = 10;
   localparam int NV = 28;

   logic        clk = 1'b0;
   logic        hresetn = 1'b0;
   logic        hsel = 1'b0, hwrite = 1'b0, hready = 1'b1;
   logic [AW-1:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic [2:0]  hsize = 3'd2;
   logic [31:0] hwdata = '0;
   logic        hreadyout;
   logic [1:0]  hresp;
   logic [31:0] hrdata, ram_wdata;
   logic [31:0] ram_rdata = '0;
   logic        ram_ce;
   logic [3:0]  ram_we;
   logic [AW-3:0] ram_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ahbram_bridge #(.AW(AW)) dut (
      .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
      .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata), .ram_ce(ram_ce),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   logic [31:0] mem [0:(1<<(AW-2))-1];
   initial for (int k = 0; k < (1<<(AW-2)); k++) mem[k] = '0;
   always @(posedge clk) begin
      if (ram_ce) begin
         for (int l = 0; l < 4; l++)
            if (ram_we[l]) mem[ram_addr][8*l +: 8] <= ram_wdata[8*l +: 8];
         if (ram_we == 4'b0000) ram_rdata <= mem[ram_addr];
      end
   end

   logic [7:0] refm [0:(1<<AW)-1];
   initial for (int k = 0; k < (1<<AW); k++) refm[k] = 8'h00;

   // kind: 0 IDLE, 1 WR, 2 RD, 3 WR hsel low, 4 WR BUSY, 5 WR hready low, 6 RD SEQ
   localparam logic [46:0] VEC [NV] = '{
      {3'd1, 2'd2, 10'h010, 32'hDEADBEEF},
      {3'd2, 2'd2, 10'h010, 32'h0},
      {3'd2, 2'd0, 10'h013, 32'h0},
      {3'd0, 2'd2, 10'h000, 32'h0},
      {3'd2, 2'd2, 10'h010, 32'h0},
      {3'd1, 2'd0, 10'h011, 32'h0000AA00},
      {3'd1, 2'd1, 10'h012, 32'h55660000},
      {3'd2, 2'd2, 10'h010, 32'h0},
      {3'd6, 2'd2, 10'h014, 32'h0},
      {3'd3, 2'd2, 10'h014, 32'hFFFFFFFF},
      {3'd0, 2'd2, 10'h000, 32'h0},
      {3'd4, 2'd2, 10'h018, 32'hFFFFFFFF},
      {3'd5, 2'd2, 10'h01C, 32'hFFFFFFFF},
      {3'd0, 2'd2, 10'h000, 32'h0},
      {3'd2, 2'd2, 10'h014, 32'h0},
      {3'd2, 2'd2, 10'h018, 32'h0},
      {3'd2, 2'd2, 10'h01C, 32'h0},
      {3'd1, 2'd1, 10'h020, 32'h0000BEEF},
      {3'd1, 2'd0, 10'h022, 32'h00110000},
      {3'd1, 2'd0, 10'h023, 32'h77000000},
      {3'd2, 2'd2, 10'h020, 32'h0},
      {3'd2, 2'd2, 10'h3FC, 32'h0},
      {3'd1, 2'd2, 10'h3FC, 32'h12345678},
      {3'd1, 2'd2, 10'h000, 32'hA5A5A5A5},
      {3'd2, 2'd2, 10'h3FC, 32'h0},
      {3'd2, 2'd2, 10'h000, 32'h0},
      {3'd0, 2'd2, 10'h000, 32'h0},
      {3'd0, 2'd2, 10'h000, 32'h0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic sel, input logic [1:0] tr, input logic wr,
                        input logic [2:0] sz, input logic [AW-1:0] a, input logic rdy);
      hsel = sel; htrans = tr; hwrite = wr; hsize = sz; haddr = a; hready = rdy;
   endtask

   task automatic idle();
      drive(1'b1, 2'b00, 1'b0, 3'd2, '0, 1'b1);
   endtask

   task automatic ref_write(input logic [2:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
      for (int l = 0; l < 4; l++) begin
         bit en;
         en = (sz == 3'd0) ? (a[1:0] == l[1:0]) : (sz == 3'd1) ? (a[1] == l[1]) : 1'b1;
         if (en) refm[{a[AW-1:2], l[1:0]}] = d[8*l +: 8];
      end
   endtask

   function automatic logic [31:0] ref_word(input logic [AW-1:0] a);
      return {refm[{a[AW-1:2], 2'd3}], refm[{a[AW-1:2], 2'd2}],
              refm[{a[AW-1:2], 2'd1}], refm[{a[AW-1:2], 2'd0}]};
   endfunction

   task automatic strobe_case(input logic [2:0] sz, input logic [AW-1:0] a, input logic [3:0] exp_we);
      @(negedge clk); drive(1'b1, 2'b10, 1'b1, sz, a, 1'b1);
      @(negedge clk); idle(); hwdata = 32'h0F1E2D3C; #1;
      check("R4 strobes", {28'd0, ram_we}, {28'd0, exp_we});
      check("R6 write-through", {31'd0, ram_ce}, 32'd1);
      check("R3 write word addr", {{(32-(AW-2)){1'b0}}, ram_addr}, {{(32-(AW-2)){1'b0}}, a[AW-1:2]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0]  pk;
      logic [31:0] pd, pe;
      pk = 3'd0; pd = '0; pe = '0;
      // Reset: an active read request must not reach the RAM
      drive(1'b1, 2'b10, 1'b0, 3'd2, 10'h040, 1'b1);
      repeat (3) @(negedge clk);
      #1;
      check("R8 ce in reset", {31'd0, ram_ce}, 32'd0);
      check("R8 we in reset", {28'd0, ram_we}, 32'd0);
      check("R1 readyout", {31'd0, hreadyout}, 32'd1);
      check("R9 addr width", $bits(ram_addr), AW - 2);
      idle();
      @(negedge clk); hresetn = 1'b1;

      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (pk == 3'd2 || pk == 3'd6) check("R5/R7 read data", hrdata, pe);
         check("R1 ready/okay", {29'd0, hresp, hreadyout}, 32'd1);
         hwdata = pd;
         if (i == NV) begin
            idle(); pk = 3'd0;
         end else begin
            logic [2:0] k;
            logic [2:0] sz;
            logic [AW-1:0] a;
            k = VEC[i][46:44]; sz = {1'b0, VEC[i][43:42]}; a = VEC[i][41:32];
            pd = VEC[i][31:0];
            case (k)
               3'd1: begin drive(1'b1, 2'b10, 1'b1, sz, a, 1'b1); ref_write(sz, a, pd); end
               3'd2: begin drive(1'b1, 2'b10, 1'b0, sz, a, 1'b1); pe = ref_word(a); end
               3'd3: drive(1'b0, 2'b10, 1'b1, sz, a, 1'b1);
               3'd4: drive(1'b1, 2'b01, 1'b1, sz, a, 1'b1);
               3'd5: drive(1'b1, 2'b10, 1'b1, sz, a, 1'b0);
               3'd6: begin drive(1'b1, 2'b11, 1'b0, sz, a, 1'b1); pe = ref_word(a); end
               default: idle();
            endcase
            pk = k;
         end
      end
      // R2: ignored writes left words 0x014, 0x018, 0x01C at zero (checked in the table)

      @(negedge clk); idle();
      strobe_case(3'd0, 10'h046, 4'b0100);
      strobe_case(3'd1, 10'h04A, 4'b1100);
      strobe_case(3'd0, 10'h04C, 4'b0001);
      strobe_case(3'd1, 10'h050, 4'b0011);
      strobe_case(3'd2, 10'h054, 4'b1111);

      // R3: read uses the port in its own address phase
      @(negedge clk); drive(1'b1, 2'b10, 1'b0, 3'd0, 10'h0A9, 1'b1); #1;
      check("R3 read ce", {31'd0, ram_ce}, 32'd1);
      check("R3 read we", {28'd0, ram_we}, 32'd0);
      check("R3 read addr", {{(32-(AW-2)){1'b0}}, ram_addr}, 32'h2A);

      // R6: write parked behind a read, then issued on the next free cycle
      @(negedge clk); drive(1'b1, 2'b10, 1'b1, 3'd2, 10'h0B0, 1'b1);
      @(negedge clk); drive(1'b1, 2'b10, 1'b0, 3'd2, 10'h0C0, 1'b1); hwdata = 32'h13572468; #1;
      check("R6 parked no write", {28'd0, ram_we}, 32'd0);
      @(negedge clk); idle(); #1;
      check("R5 unrelated read", hrdata, 32'h0);
      check("R6 commit strobes", {28'd0, ram_we}, 32'hF);
      check("R6 commit addr", {{(32-(AW-2)){1'b0}}, ram_addr}, 32'h2C);
      @(negedge clk); #1;
      check("R6 single commit", {31'd0, ram_ce}, 32'd0);
      @(negedge clk); drive(1'b1, 2'b10, 1'b0, 3'd2, 10'h0B0, 1'b1);
      @(negedge clk); idle(); #1;
      check("R6 committed data", hrdata, 32'h13572468);

      // R8: reset drops a parked write
      @(negedge clk); drive(1'b1, 2'b10, 1'b1, 3'd2, 10'h100, 1'b1);
      @(negedge clk); drive(1'b1, 2'b10, 1'b0, 3'd2, 10'h104, 1'b1); hwdata = 32'hCAFEF00D;
      @(negedge clk); idle(); hresetn = 1'b0; #1;
      check("R8 no commit in reset", {27'd0, ram_ce, ram_we}, 32'd0);
      @(negedge clk); hresetn = 1'b1;
      @(negedge clk); #1;
      check("R8 nothing after reset", {31'd0, ram_ce}, 32'd0);
      drive(1'b1, 2'b10, 1'b0, 3'd2, 10'h100, 1'b1);
      @(negedge clk); idle(); #1;
      check("R8 dropped write", hrdata, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule